// File: doc/BRIEF.md
# Registered Five-Function ALU

This block combines two operands into a single result using one of five operations: addition, subtraction, bitwise AND, bitwise OR and bitwise XOR. The operation is chosen by a sparse three-bit function code. The result, an unsigned carry flag and a signed overflow flag are captured together in an output register on the rising clock edge. The value therefore appears one cycle after the inputs are presented.

The datapath is an array of identical one-bit cells. Each cell holds a full adder whose B input can be inverted for subtraction, along with the three logic gates. A per-bit multiplexer picks one of these outputs. Subtraction is formed as A + ~B + 1. The carry flag is taken straight from the top adder stage. For subtraction it therefore means "no borrow".

Top module: `alu5_reg`

## Requirements
- R1: With func = 3'b000, on the clock edge after the inputs are applied, res equals (a + b) mod 2^W and cout equals 1 exactly when a + b >= 2^W, treating a and b as unsigned.
- R2: With func = 3'b001, one edge later, res equals (a - b) mod 2^W and cout equals 1 exactly when a >= b as unsigned values.
- R3: For add and subtract, one edge later, ovf equals 1 exactly when the signed two's-complement result lies outside [-2^(W-1), 2^(W-1)-1].
- R4: With func = 3'b010, 3'b100 or 3'b111, one edge later, res is a AND b, a OR b or a XOR b respectively.
- R5: For the three logic codes, cout and ovf are 0 one edge later.
- R6: For the unused codes 3'b011, 3'b101 and 3'b110, res, cout and ovf are all 0 one edge later.
- R7: While rst is 1 at a rising edge, res, cout and ovf become 0 after that edge, whatever the other inputs are.
- R8: Outputs change only at rising clock edges. Each registered value reflects the inputs present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | W (4) | First operand |
| b | input | W (4) | Second operand |
| func | input | 3 | Function code |
| res | output | W (4) | Registered result |
| cout | output | 1 | Registered carry / no-borrow flag |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
The bench builds the block with its default width of four bits. At that width the operand space has only 256 pairs, so every operand pair can be run under all eight function codes, including the three unused codes. That sweep reaches every signed overflow boundary and every carry boundary. The eight fault-coverage adder vectors come first, as directed cases. Seeded random operations issued with reset asserted then check that reset overrides a live function.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'b000,
    FN_SUB = 3'b001,
    FN_AND = 3'b010,
    FN_OR  = 3'b100,
    FN_XOR = 3'b111
  } fn_e;

  typedef enum logic [2:0] {
    SEL_SUM  = 3'd0,
    SEL_AND  = 3'd1,
    SEL_OR   = 3'd2,
    SEL_XOR  = 3'd3,
    SEL_ZERO = 3'd4
  } sel_e;

  typedef struct packed {
    sel_e pick;
    logic inv_b;
    logic arith;
  } ctl_t;
endpackage

// File: rtl/alu5_decode.sv
module alu5_decode
  import alu5_pkg::*;
(
  input  logic [2:0] func,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '{pick: SEL_ZERO, inv_b: 1'b0, arith: 1'b0};
    unique case (func)
      FN_ADD: ctl = '{pick: SEL_SUM, inv_b: 1'b0, arith: 1'b1};
      FN_SUB: ctl = '{pick: SEL_SUM, inv_b: 1'b1, arith: 1'b1};
      FN_AND: ctl.pick = SEL_AND;
      FN_OR:  ctl.pick = SEL_OR;
      FN_XOR: ctl.pick = SEL_XOR;
      default: ctl.pick = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/alu5_slice.sv
module alu5_slice
  import alu5_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  input  ctl_t ctl,
  output logic y,
  output logic co
);
  logic bx, s;
  always_comb begin
    bx = b ^ ctl.inv_b;
    s  = a ^ bx ^ cin;
    co = (a & bx) | (cin & (a ^ bx));
    unique case (ctl.pick)
      SEL_SUM: y = s;
      SEL_AND: y = a & b;
      SEL_OR:  y = a | b;
      SEL_XOR: y = a ^ b;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu5_reg.sv
module alu5_reg
  import alu5_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   func,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  ctl_t         ctl;
  logic [W:0]   c;
  logic [W-1:0] y;
  logic         cout_d, ovf_d;

  alu5_decode u_dec (.func(func), .ctl(ctl));

  assign c[0] = ctl.inv_b;

  for (genvar i = 0; i < W; i++) begin : g_bit
    alu5_slice u_sl (
      .a(a[i]), .b(b[i]), .cin(c[i]), .ctl(ctl),
      .y(y[i]), .co(c[i+1])
    );
  end

  assign cout_d = ctl.arith & c[W];
  assign ovf_d  = ctl.arith & (c[W] ^ c[MSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      res  <= y;
      cout <= cout_d;
      ovf  <= ovf_d;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res == '0 && !cout && !ovf)); // R7
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b000) |=> (cout == (({1'b0, $past(a)} + {1'b0, $past(b)}) >> W))); // R1
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b001) |=> (cout == ($past(a) >= $past(b)))); // R2
  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b010 || func == 3'b100 || func == 3'b111) |=> (!cout && !ovf)); // R5
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b011 || func == 3'b101 || func == 3'b110) |=> (res == '0 && !cout && !ovf)); // R6
  AST_OVF_SIGN: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b000) |=> (ovf == (($past(a[MSB]) == $past(b[MSB])) && (res[MSB] != $past(a[MSB]))))); // R3
  AST_XOR_RES: assert property (@(posedge clk) disable iff (rst)
    (func == 3'b111) |=> (res == ($past(a) ^ $past(b)))); // R4
endmodule

// File: tb/alu5_reg_tb.sv
module alu5_reg_tb;
  localparam int W = 4;
  logic clk = 0, rst = 1;
  logic [W-1:0] a = 0, b = 0;
  logic [2:0] func = 0;
  logic [W-1:0] res;
  logic cout, ovf;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu5_reg #(.W(W)) u_dut (.*);

  function automatic logic [W+1:0] model(input logic [W-1:0] x, input logic [W-1:0] z, input logic [2:0] f);
    int sx, sz, sr, ur;
    logic [W-1:0] r; logic c, v;
    sx = $signed(x); sz = $signed(z);
    r = '0; c = 0; v = 0;
    case (f)
      3'b000: begin ur = int'(x) + int'(z); r = W'(ur); c = ur >= (1 << W);
              sr = sx + sz; v = sr > 7 || sr < -8; end
      3'b001: begin r = x - z; c = x >= z; sr = sx - sz; v = sr > 7 || sr < -8; end
      3'b010: r = x & z;
      3'b100: r = x | z;
      3'b111: r = x ^ z;
      default: ;
    endcase
    return {r, c, v};
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] z, input logic [2:0] f, input logic r, input string tag);
    logic [W+1:0] exp, got;
    a = x; b = z; func = f; rst = r;
    @(posedge clk); #1;
    exp = r ? '0 : model(x, z, f);
    got = {res, cout, ovf};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h f=%b got res=%h c=%b v=%b exp res=%h c=%b v=%b",
               tag, x, z, f, got[W+1:2], got[1], got[0], exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'b000: return "R1/R3/R8";
      3'b001: return "R2/R3/R8";
      3'b010, 3'b100, 3'b111: return "R4/R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; $display("FAIL watchdog");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(17));
    apply(4'h5, 4'ha, 3'b000, 1, "R7");
    apply(4'h0, 4'h0, 3'b000, 0, "R1");
    apply(4'h5, 4'h5, 3'b000, 0, "R1");
    apply(4'ha, 4'ha, 3'b000, 0, "R1");
    apply(4'ha, 4'h5, 3'b000, 0, "R1");
    apply(4'h5, 4'ha, 3'b001, 0, "R2");
    apply(4'h0, 4'hf, 3'b001, 0, "R2");
    apply(4'hf, 4'hf, 3'b001, 0, "R2");
    apply(4'hf, 4'h0, 3'b001, 0, "R2");
    apply(4'h7, 4'h1, 3'b000, 0, "R3");
    apply(4'h8, 4'h1, 3'b001, 0, "R3");
    for (int f = 0; f < 8; f++)
      for (int x = 0; x < 16; x++)
        for (int z = 0; z < 16; z++)
          apply(W'(x), W'(z), 3'(f), 0, tag_of(3'(f)));
    for (int k = 0; k < 40; k++)
      apply(W'($urandom), W'($urandom), 3'($urandom), 1, "R7");
    for (int k = 0; k < 200; k++)
      apply(W'($urandom), W'($urandom), 3'($urandom), 0, "R8");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule